// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a supervision timer that sits on a simple single-cycle register bus. A 12-bit down-counter is decremented once for every `PRE_DIV` strobes of a slow-clock enable. Software keeps it from expiring by writing a restart command to the control word. The command counts only when its top byte carries the key value 0xA5. A restart that arrives too early counts as a fault: the counter is then still above a programmed delta threshold.

The mode word can be written once after reset. That write sets the reload value, the delta threshold, the interrupt and reset-request enables, a disable bit and two halt qualifiers. The write locks the word and also reloads the counter. An underflow or an early restart sets a sticky status flag. Reading the status word clears these flags. Each event can drive a level interrupt, a one-cycle reset request, or both, toward controllers outside the block.

Top module: `wdt_keyed`

## Requirements
- R1: After a mode write, with the slow strobe high every cycle, the counter steps down once every `PRE_DIV` strobes. The underflow (counter reaching 0) is flagged exactly `reload * PRE_DIV` clock edges after the write.
- R2: A control write (address 0) restarts the counter only when bit 0 is 1 and bits 31:24 equal 0xA5. Any other key has no effect on the counter or the flags.
- R3: A keyed restart while the counter is greater than the delta value sets status bit 1 and leaves the counter untouched. At or below the delta value it reloads the counter and clears the prescaler.
- R4: The mode word (address 1) takes its first write only. Later writes are ignored until reset. It reads back as: bits 11:0 reload, bit 12 interrupt enable, bit 13 reset-request enable, bit 15 disable, bits 27:16 delta, bit 28 debug halt, bit 29 idle halt, all others 0.
- R5: A mode write loads the counter with the newly written reload value and clears the prescaler.
- R6: After reset the mode word reads 0x0FFF2FFF: reload 0xFFF, delta 0xFFF, reset request enabled, interrupt disabled, watchdog running. The status reads 0, and both outputs are low.
- R7: An underflow sets status bit 0. While bit 12 is set, `irq_o` is high whenever a status flag is set. While bit 13 is set, each underflow or window error gives a one-cycle `rst_req_o` pulse, in the cycle after the event edge.
- R8: Reading status (address 2) returns {bit1 error, bit0 underflow} and clears both flags at that edge. A new event in the same cycle wins over the clear.
- R9: While the disable bit is set, the counter and prescaler hold, and keyed restarts are ignored (no error).
- R10: While `dbg_halt_i` is high with bit 28 set, or `idle_halt_i` is high with bit 29 set, the counter and prescaler hold. A halt input whose bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow-clock strobe, one cycle per slow period |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Word address: 0 control, 1 mode, 2 status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| dbg_halt_i | input | 1 | Debug state indication |
| idle_halt_i | input | 1 | Idle state indication |
| irq_o | output | 1 | Fault interrupt level |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The bench builds the block with `PRE_DIV` set to 4 and the key left at 0xA5. With that divider a 12-bit reload of a few units expires in tens of cycles. Exact underflow edges, window boundaries at delta and delta+1, and the halt and disable freezes can therefore all be checked on a cycle count. The table of window vectors places restarts on both sides of the threshold and on and off prescaler wrap edges.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int CNT_W = 12;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic             idle_hlt;
    logic             dbg_hlt;
    logic [CNT_W-1:0] delta;
    logic             dis;
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] reload;
  } mode_t;

  localparam mode_t MODE_RST = '{idle_hlt: 1'b0, dbg_hlt: 1'b0, delta: '1,
                                 dis: 1'b0, rst_en: 1'b1, irq_en: 1'b0,
                                 reload: '1};

  function automatic mode_t mode_from_word(logic [31:0] w);
    mode_t m;
    m.reload   = w[11:0];
    m.irq_en   = w[12];
    m.rst_en   = w[13];
    m.dis      = w[15];
    m.delta    = w[27:16];
    m.dbg_hlt  = w[28];
    m.idle_hlt = w[29];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_word(mode_t m);
    return {2'b00, m.idle_hlt, m.dbg_hlt, m.delta, m.dis, 1'b0,
            m.rst_en, m.irq_en, m.reload};
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic          wrap;

  assign wrap   = (pre_q == LAST);
  assign tick_o = en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (en_i)   pre_q <= wrap ? '0 : pre_q + PW'(1);
  end

  assert_prescale_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);

  assert_prescale_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_wr_i,
  input  logic [W-1:0] wr_reload_i,
  input  logic         restart_i,
  input  logic [W-1:0] reload_i,
  input  logic [W-1:0] delta_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         load_o,
  output logic         unf_o,
  output logic         err_o
);
  logic [W-1:0] cnt_q;

  // early restart: outside the window, counter keeps running
  assign err_o  = restart_i & (cnt_q > delta_i);
  assign load_o = mode_wr_i | (restart_i & ~err_o);
  assign unf_o  = tick_i & run_i & ~load_o & (cnt_q == W'(1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '1;
    else if (mode_wr_i)                cnt_q <= wr_reload_i;
    else if (restart_i && !err_o)      cnt_q <= reload_i;
    else if (tick_i && run_i)          cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - W'(1);
  end

  assert_frozen_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_o) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_keyed_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        unf_i,
  input  logic        err_i,
  output logic [31:0] rdata_o,
  output mode_t       mode_o,
  output logic        mode_wr_o,
  output logic        restart_o,
  output logic        unf_flag_o,
  output logic        err_flag_o
);
  mode_t mode_q;
  logic  locked_q;
  logic  unf_q, err_q;
  logic  stat_rd;

  assign mode_wr_o = wr_i & (addr_i == ADDR_MODE) & ~locked_q;
  assign restart_o = wr_i & (addr_i == ADDR_CTRL) & wdata_i[0] &
                     (wdata_i[31:24] == KEY) & ~mode_q.dis;
  assign stat_rd   = rd_i & (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RST;
      locked_q <= 1'b0;
    end else if (mode_wr_o) begin
      mode_q   <= mode_from_word(wdata_i);
      locked_q <= 1'b1;
    end
  end

  // set beats clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      unf_q <= unf_i | (unf_q & ~stat_rd);
      err_q <= err_i | (err_q & ~stat_rd);
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_MODE: rdata_o = mode_to_word(mode_q);
      ADDR_STAT: rdata_o = {30'd0, err_q, unf_q};
      default:   rdata_o = '0;
    endcase
  end

  assign mode_o     = mode_q;
  assign unf_flag_o = unf_q;
  assign err_flag_o = err_q;

  assert_mode_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> (locked_q && $stable(mode_q)));

  assert_status_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !unf_i && !err_i) |=> (!unf_q && !err_q));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int         PRE_DIV = 128,
  parameter logic [7:0] KEY     = 8'hA5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slow_tick_i,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        dbg_halt_i,
  input  logic        idle_halt_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  mode_t            mode;
  logic             mode_wr, restart, load, tick, run;
  logic             unf_evt, err_evt, unf_flag, err_flag;
  logic [CNT_W-1:0] cnt;
  logic             rst_req_q;

  assign run = ~mode.dis & ~(dbg_halt_i & mode.dbg_hlt) & ~(idle_halt_i & mode.idle_hlt);

  wdt_regs #(.KEY(KEY)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .unf_i      (unf_evt),
    .err_i      (err_evt),
    .rdata_o    (bus_rdata_o),
    .mode_o     (mode),
    .mode_wr_o  (mode_wr),
    .restart_o  (restart),
    .unf_flag_o (unf_flag),
    .err_flag_o (err_flag)
  );

  wdt_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .en_i   (slow_tick_i & run),
    .tick_o (tick)
  );

  wdt_down_counter #(.W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_wr_i   (mode_wr),
    .wr_reload_i (bus_wdata_i[CNT_W-1:0]),
    .restart_i   (restart),
    .reload_i    (mode.reload),
    .delta_i     (mode.delta),
    .run_i       (run),
    .tick_i      (tick),
    .cnt_o       (cnt),
    .load_o      (load),
    .unf_o       (unf_evt),
    .err_o       (err_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= mode.rst_en & (unf_evt | err_evt);
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = mode.irq_en & (unf_flag | err_flag);

  assert_window_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && (cnt > mode.delta)) |=> err_flag);

  assert_rst_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(mode.rst_en));
endmodule

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;
  localparam int PRE = 4;
  localparam logic [31:0] KEYED = 32'hA500_0001;
  localparam logic [31:0] BADKEY = 32'h5A00_0001;
  // reload, delta, idle edges before restart
  localparam int unsigned VEC [8][3] = '{
    '{10, 5, 8}, '{10, 5, 20}, '{10, 5, 24}, '{10, 5, 23},
    '{10, 5, 19}, '{12, 12, 0}, '{6, 0, 20}, '{200, 100, 400}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dbg = 1'b0, idle = 1'b0;
  logic        irq, rst_req;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wdt_keyed #(.PRE_DIV(PRE), .KEY(8'hA5)) uut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .dbg_halt_i(dbg), .idle_halt_i(idle),
    .irq_o(irq), .rst_req_o(rst_req));

  function automatic logic [31:0] mw(int r, int d, bit ien, bit ren, bit dis, bit dh, bit ih);
    return {2'b00, ih, dh, 12'(d), dis, 1'b0, ren, ien, 12'(r)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 0; rd = 0; dbg = 0; idle = 0; slow_tick = 1'b1;
    idle_n(2);
    rst_n = 1'b1;
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    // vector table: window check around delta
    foreach (VEC[i]) begin
      int r = int'(VEC[i][0]);
      int d = int'(VEC[i][1]);
      int n = int'(VEC[i][2]);
      int c;
      bit e;
      c = r - n / PRE;
      e = (c > d);
      do_reset();
      bus_wr(2'd1, mw(r, d, 1, 1, 0, 0, 0));
      idle_n(n);
      bus_wr(2'd0, KEYED);
      chk($sformatf("R3 vec%0d irq", i), {31'd0, irq}, {31'd0, e});
      chk($sformatf("R7 vec%0d rst_req", i), {31'd0, rst_req}, {31'd0, e});
      bus_rd(2'd2, v);
      chk($sformatf("R8 vec%0d status", i), v, {30'd0, e, 1'b0});
    end

    // R6 reset defaults
    do_reset();
    chk("R6 irq", {31'd0, irq}, 32'd0);
    chk("R6 rst_req", {31'd0, rst_req}, 32'd0);
    bus_rd(2'd1, v); chk("R6 mode", v, 32'h0FFF_2FFF);
    bus_rd(2'd2, v); chk("R6 status", v, 32'd0);

    // R4 write once
    bus_wr(2'd1, mw(9, 7, 1, 0, 0, 1, 0));
    bus_wr(2'd1, mw(3, 2, 0, 1, 1, 0, 1));
    bus_rd(2'd1, v); chk("R4 mode locked", v, mw(9, 7, 1, 0, 0, 1, 0));

    // R1 R2 underflow timing, bad key ignored
    do_reset();
    bus_wr(2'd1, mw(3, 4095, 1, 1, 0, 0, 0));
    idle_n(5);
    bus_wr(2'd0, BADKEY);
    idle_n(5);
    chk("R2 bad key, R1 before underflow", {30'd0, rst_req, irq}, 32'd0);
    idle_n(1);
    chk("R1 underflow edge irq", {31'd0, irq}, 32'd1);
    chk("R7 rst_req pulse", {31'd0, rst_req}, 32'd1);
    idle_n(1);
    chk("R7 rst_req single cycle", {31'd0, rst_req}, 32'd0);
    bus_rd(2'd2, v); chk("R8 status underflow", v, 32'd1);
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);
    bus_rd(2'd2, v); chk("R8 status cleared", v, 32'd0);

    // R5 R3 in-window restart reloads counter and prescaler
    do_reset();
    bus_wr(2'd1, mw(3, 4095, 1, 0, 0, 0, 0));
    idle_n(8);
    bus_wr(2'd0, KEYED);
    idle_n(11);
    chk("R3 reload delays underflow", {31'd0, irq}, 32'd0);
    idle_n(1);
    chk("R5 underflow after reload", {31'd0, irq}, 32'd1);
    chk("R7 no rst_req when disabled", {31'd0, rst_req}, 32'd0);

    // R9 disable bit
    do_reset();
    bus_wr(2'd1, mw(2, 0, 1, 1, 1, 0, 0));
    idle_n(100);
    chk("R9 frozen no underflow", {30'd0, rst_req, irq}, 32'd0);
    bus_wr(2'd0, KEYED);
    chk("R9 restart ignored", {30'd0, rst_req, irq}, 32'd0);
    bus_rd(2'd2, v); chk("R9 status", v, 32'd0);

    // R10 debug halt enabled
    do_reset();
    bus_wr(2'd1, mw(2, 4095, 1, 0, 0, 1, 0));
    dbg = 1'b1;
    idle_n(50);
    dbg = 1'b0;
    idle_n(7);
    chk("R10 debug halt holds", {31'd0, irq}, 32'd0);
    idle_n(1);
    chk("R10 underflow after halt", {31'd0, irq}, 32'd1);

    // R10 idle input without its bit
    do_reset();
    bus_wr(2'd1, mw(2, 4095, 1, 0, 0, 0, 0));
    idle = 1'b1;
    idle_n(7);
    chk("R10 idle unqualified early", {31'd0, irq}, 32'd0);
    idle_n(1);
    chk("R10 idle unqualified no effect", {31'd0, irq}, 32'd1);
    idle = 1'b0;

    // R10 idle halt enabled
    do_reset();
    bus_wr(2'd1, mw(2, 4095, 1, 0, 0, 0, 1));
    idle = 1'b1;
    idle_n(40);
    chk("R10 idle halt holds", {31'd0, irq}, 32'd0);
    idle = 1'b0;

    // R1 slow strobe gating: half-rate strobe doubles period
    do_reset();
    bus_wr(2'd1, mw(1, 4095, 1, 0, 0, 0, 0));
    for (int k = 0; k < 7; k++) begin
      slow_tick = k[0];
      idle_n(1);
    end
    slow_tick = 1'b1;
    chk("R1 strobe gating early", {31'd0, irq}, 32'd0);
    idle_n(1);
    chk("R1 strobe gating underflow", {31'd0, irq}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule